// File: doc/BRIEF.md
# I/O Page-Table Address Translator

This block turns DMA addresses issued by PCI devices into system physical addresses, one 4 KiB page at a time. A requester presents an address on a valid/ready request channel. The block drops the in-page offset and decides whether the page falls inside a programmable translation window. If it does, the block reads one 64-bit directory entry from memory and builds the physical page address from it. If it does not, the block returns a fixed default mapping. The response carries the translated page address, a 12-bit offset mask and a read/write permission code.

Three registers control the window: a window base (bit 0 of which enables translation), a window mask and a directory base. Two more registers, config and purge, are kept for software but do not change the datapath. All five are reached over a 64-bit register port. That port accepts full 8-byte writes and 4-byte writes to either half. The block has no entry cache, so every request inside the window fetches its entry again, and it holds only one request at a time.

Top module: `iopt_xlate`

## Requirements
- R1: After reset, all five registers read zero, `req_ready_o` is high, and `rsp_valid_o` and `mem_req_o` are low.
- R2: Register byte offsets are 0x00 window base, 0x08 window mask, 0x10 directory base, 0x18 config and 0x20 purge. An 8-byte write replaces the whole register. A 4-byte write replaces only bits 63:32 when address bit 2 is set, and only bits 31:0 otherwise, taking its data from `reg_wdata_i[31:0]`. Other offsets read zero and ignore writes.
- R3: When window-base bit 0 is clear, a request gets the default mapping with permission 2'b11 (bit 0 read, bit 1 write), and no memory read is issued.
- R4: When translation is enabled but (page & mask) differs from the window base with bit 0 cleared, the request gets the default mapping with permission 2'b11, and no memory read is issued.
- R5: For a page inside the window, the block issues one memory read at directory_base + (page_address >> 12) * 8.
- R6: A fetched entry with bit 63 set gives a response address equal to the entry with bit 63 and bits 11:0 cleared, and permission 2'b11.
- R7: A fetched entry with bit 63 clear gives permission 2'b00 (fault) and response address zero.
- R8: Bits 11:0 of the request address never affect the result, and every response reports the offset mask 0xfff.
- R9: The default mapping passes the page address through unchanged for addresses both below and above 4 GiB.
- R10: A bypassed request (R3, R4) raises `rsp_valid_o` on the clock edge right after the request is accepted.
- R11: Only one request is in flight. `req_ready_o` stays low from acceptance until the response is taken, and a pending response holds its address and permission stable while `rsp_ready_i` is low.
- R12: `mem_req_o` and `mem_addr_o` hold steady until `mem_rvalid_i` returns the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_size8_i | input | 1 | 1: 8-byte write, 0: 4-byte write |
| reg_addr_i | input | 6 | Register byte address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Read data of the addressed register |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Translation request ready |
| req_addr_i | input | 64 | DMA address to translate |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response accepted |
| rsp_addr_o | output | 64 | Translated page address |
| rsp_mask_o | output | 12 | Offset mask |
| rsp_perm_o | output | 2 | Permission: bit 0 read, bit 1 write |
| mem_req_o | output | 1 | Directory entry read request |
| mem_addr_o | output | 64 | Directory entry byte address |
| mem_rvalid_i | input | 1 | Directory entry returned |
| mem_rdata_i | input | 64 | Directory entry, little-endian 64-bit |

## Verification
Some properties are checked on every cycle: one transaction at a time, stable pending responses and memory requests, and permission codes limited to none or read/write. The assertions also check that bypassed requests answer on the next edge, that in-window requests raise a memory read at the computed entry address, and that a low-half register write leaves the high half alone. Other behaviour can only be shown by the bench scenarios. These are the actual address values produced by the default mapping, entry decoding for valid and faulting entries, the window decision for addresses inside and outside the window, and readback of each register after full and half writes.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_RESP} iopt_state_e;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RW   = 2'b11;

  localparam int unsigned REG_BASE  = 0;
  localparam int unsigned REG_MASK  = 1;
  localparam int unsigned REG_DIR   = 2;
  localparam int unsigned REG_CFG   = 3;
  localparam int unsigned REG_PURGE = 4;
  localparam int unsigned NUM_REGS  = 5;
endpackage

// File: rtl/iopt_regs.sv
module iopt_regs
  import iopt_pkg::*;
#(
  parameter int unsigned DW     = 64,
  parameter int unsigned REG_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              size8_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     base_o,
  output logic [DW-1:0]     mask_o,
  output logic [DW-1:0]     dirbase_o
);
  localparam int unsigned HALF  = DW / 2;
  localparam int unsigned IDX_W = REG_AW - 3;

  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    regs_q [NUM_REGS];

  assign idx = addr_i[REG_AW-1:3];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[i] <= '0;
      end else if (wr_i && (idx == IDX_W'(i))) begin
        if (size8_i)        regs_q[i] <= wdata_i;
        else if (addr_i[2]) regs_q[i][DW-1:HALF] <= wdata_i[HALF-1:0];
        else                regs_q[i][HALF-1:0]  <= wdata_i[HALF-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) rdata_o = regs_q[i];
    end
  end

  assign base_o    = regs_q[REG_BASE];
  assign mask_o    = regs_q[REG_MASK];
  assign dirbase_o = regs_q[REG_DIR];

  // R2: a low-half write leaves the high half untouched
  assert_half_lo_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !size8_i && !addr_i[2] && idx == IDX_W'(REG_BASE))
      |=> $stable(base_o[DW-1:HALF]));
endmodule

// File: rtl/iopt_match.sv
module iopt_match #(
  parameter int unsigned AW          = 64,
  parameter int unsigned PAGE_SHIFT  = 12,
  parameter int unsigned ENTRY_SHIFT = 3
) (
  input  logic [AW-1:0] page_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] mask_i,
  input  logic [AW-1:0] dirbase_i,
  output logic          hit_o,
  output logic [AW-1:0] dflt_o,
  output logic [AW-1:0] entry_addr_o
);
  localparam int unsigned NARROW_W = 32;

  // Fixed default mapping; identity, zero-extended for narrow addresses.
  function automatic logic [AW-1:0] narrow_to_wide(input logic [AW-1:0] a);
    if (a[AW-1:NARROW_W] == '0) return {{(AW-NARROW_W){1'b0}}, a[NARROW_W-1:0]};
    return a;
  endfunction

  logic en;
  assign en           = base_i[0];
  assign hit_o        = en && ((page_i & mask_i) == {base_i[AW-1:1], 1'b0});
  assign dflt_o       = narrow_to_wide(page_i);
  assign entry_addr_o = dirbase_i + ((page_i >> PAGE_SHIFT) << ENTRY_SHIFT);
endmodule

// File: rtl/iopt_walk.sv
module iopt_walk
  import iopt_pkg::*;
#(
  parameter int unsigned AW         = 64,
  parameter int unsigned DW         = 64,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          hit_i,
  input  logic [AW-1:0] dflt_i,
  input  logic [AW-1:0] entry_addr_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [AW-1:0] rsp_addr_o,
  output logic [1:0]    rsp_perm_o
);
  iopt_state_e   state_q;
  logic [AW-1:0] mem_addr_q, rsp_addr_q;
  logic [1:0]    perm_q;
  logic          accept;

  assign accept      = req_valid_i && req_ready_o;
  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_FETCH);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign mem_addr_o  = mem_addr_q;
  assign rsp_addr_o  = rsp_addr_q;
  assign rsp_perm_o  = perm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mem_addr_q <= '0;
      rsp_addr_q <= '0;
      perm_q     <= PERM_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          if (hit_i) begin
            mem_addr_q <= entry_addr_i;
            state_q    <= ST_FETCH;
          end else begin
            rsp_addr_q <= dflt_i;
            perm_q     <= PERM_RW;
            state_q    <= ST_RESP;
          end
        end
        ST_FETCH: if (mem_rvalid_i) begin
          if (mem_rdata_i[DW-1]) begin
            rsp_addr_q <= AW'({1'b0, mem_rdata_i[DW-2:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}});
            perm_q     <= PERM_RW;
          end else begin
            rsp_addr_q <= '0;
            perm_q     <= PERM_NONE;
          end
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_one_inflight_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && (rsp_valid_o || mem_req_o)));

  assert_rsp_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_addr_o) && $stable(rsp_perm_o)));

  assert_mem_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_bypass_next_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !hit_i) |=> (rsp_valid_o && rsp_perm_o == PERM_RW && !mem_req_o));

  assert_fetch_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit_i) |=> (mem_req_o && mem_addr_o == $past(entry_addr_i)));

  assert_perm_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_perm_o == PERM_RW || rsp_perm_o == PERM_NONE));

  assert_page_align_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_addr_o[PAGE_SHIFT-1:0] == '0));
endmodule

// File: rtl/iopt_xlate.sv
module iopt_xlate #(
  parameter int unsigned AW          = 64,
  parameter int unsigned DW          = 64,
  parameter int unsigned REG_AW      = 6,
  parameter int unsigned PAGE_SHIFT  = 12,
  parameter int unsigned ENTRY_SHIFT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_size8_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [AW-1:0]     req_addr_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [AW-1:0]     rsp_addr_o,
  output logic [PAGE_SHIFT-1:0] rsp_mask_o,
  output logic [1:0]        rsp_perm_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i
);
  logic [DW-1:0] base, mask, dirbase;
  logic [AW-1:0] page, dflt, entry_addr;
  logic          hit;

  assign page       = {req_addr_i[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  assign rsp_mask_o = '1;

  iopt_regs #(.DW(DW), .REG_AW(REG_AW)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .size8_i(reg_size8_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .base_o(base), .mask_o(mask), .dirbase_o(dirbase)
  );

  iopt_match #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT), .ENTRY_SHIFT(ENTRY_SHIFT)) u_match (
    .page_i(page), .base_i(AW'(base)), .mask_i(AW'(mask)), .dirbase_i(AW'(dirbase)),
    .hit_o(hit), .dflt_o(dflt), .entry_addr_o(entry_addr)
  );

  iopt_walk #(.AW(AW), .DW(DW), .PAGE_SHIFT(PAGE_SHIFT)) u_walk (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o,
    .hit_i(hit), .dflt_i(dflt), .entry_addr_i(entry_addr),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .rsp_valid_o, .rsp_ready_i, .rsp_addr_o, .rsp_perm_o
  );
endmodule

// File: tb/iopt_xlate_tb.sv
module iopt_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0, reg_size8_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [63:0] reg_wdata_i = '0, reg_rdata_o;
  logic        req_valid_i = 1'b0, req_ready_o;
  logic [63:0] req_addr_i = '0;
  logic        rsp_valid_o, rsp_ready_i = 1'b0;
  logic [63:0] rsp_addr_o;
  logic [11:0] rsp_mask_o;
  logic [1:0]  rsp_perm_o;
  logic        mem_req_o;
  logic [63:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  iopt_xlate u_dut (.clk_i(clk), .*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input bit s8, input logic [63:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_size8_i = s8; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [63:0] exp);
    @(negedge clk);
    reg_addr_i = a;
    #1 chk(tag, reg_rdata_o, exp);
  endtask

  // Present a request, accepted at the next posedge; returns at the following negedge.
  task automatic issue(input logic [63:0] a);
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = a;
    @(negedge clk);
    req_valid_i = 1'b0; req_addr_i = '1;
  endtask

  task automatic take_rsp(input string tag, input logic [63:0] ea, input logic [1:0] ep);
    chk({tag, " rsp_valid"}, rsp_valid_o, 1);
    chk({tag, " addr"}, rsp_addr_o, ea);
    chk({tag, " perm"}, rsp_perm_o, ep);
    chk({tag, " R8 mask"}, rsp_mask_o, 64'hfff);
    rsp_ready_i = 1'b1;
    @(negedge clk);
    rsp_ready_i = 1'b0;
    chk({tag, " R11 ready after take"}, req_ready_o, 1);
    chk({tag, " R11 rsp dropped"}, rsp_valid_o, 0);
  endtask

  task automatic t_reset;
    chk("R1 ready", req_ready_o, 1);
    chk("R1 rsp_valid", rsp_valid_o, 0);
    chk("R1 mem_req", mem_req_o, 0);
    for (int i = 0; i < 5; i++) rd_chk("R1 reg zero", 6'(i * 8), 0);
  endtask

  task automatic t_regs;
    wr(6'h00, 1, 64'h1122334455667788);
    rd_chk("R2 full write", 6'h00, 64'h1122334455667788);
    wr(6'h00, 0, 64'hFFFFFFFFAAAABBBB);
    rd_chk("R2 low half", 6'h00, 64'h11223344AAAABBBB);
    wr(6'h04, 0, 64'h00000000CCCCDDDD);
    rd_chk("R2 high half", 6'h00, 64'hCCCCDDDDAAAABBBB);
    wr(6'h18, 1, 64'h0123);
    rd_chk("R2 config", 6'h18, 64'h0123);
    wr(6'h20, 1, 64'h4567);
    rd_chk("R2 purge", 6'h20, 64'h4567);
    wr(6'h28, 1, 64'hDEAD);
    rd_chk("R2 unmapped reads zero", 6'h28, 0);
    rd_chk("R2 unmapped write no effect on base", 6'h00, 64'hCCCCDDDDAAAABBBB);
    wr(6'h00, 1, 64'h0);
  endtask

  task automatic t_disabled;
    wr(6'h08, 1, 64'h0);
    issue(64'h0000_0000_1234_5ABC);
    chk("R3 R10 no mem read", mem_req_o, 0);
    take_rsp("R3 R9 R10 low addr", 64'h0000_0000_1234_5000, 2'b11);
    issue(64'h0000_00AB_CDEF_1FFF);
    take_rsp("R3 R9 high addr", 64'h0000_00AB_CDEF_1000, 2'b11);
  endtask

  task automatic t_window_setup;
    wr(6'h00, 1, 64'h0000_0000_8000_0001);
    wr(6'h08, 1, 64'hFFFF_FFFF_F000_0000);
    wr(6'h10, 1, 64'h0000_0001_0000_0000);
  endtask

  task automatic t_miss;
    issue(64'h0000_0000_9000_0123);
    chk("R4 no mem read", mem_req_o, 0);
    take_rsp("R4 miss", 64'h0000_0000_9000_0000, 2'b11);
  endtask

  task automatic t_hit_valid;
    issue(64'h0000_0000_8003_4567);
    chk("R5 mem_req", mem_req_o, 1);
    chk("R5 entry addr", mem_addr_o, 64'h0000_0001_0040_01A0);
    chk("R11 busy", req_ready_o, 0);
    @(negedge clk);
    chk("R12 mem_req held", mem_req_o, 1);
    chk("R12 addr held", mem_addr_o, 64'h0000_0001_0040_01A0);
    mem_rvalid_i = 1'b1; mem_rdata_i = 64'h8000_0012_3456_7FFF;
    @(negedge clk);
    mem_rvalid_i = 1'b0; mem_rdata_i = '0;
    chk("R12 mem_req dropped", mem_req_o, 0);
    chk("R11 still busy", req_ready_o, 0);
    @(negedge clk);
    chk("R11 rsp held valid", rsp_valid_o, 1);
    chk("R11 rsp held addr", rsp_addr_o, 64'h0000_0012_3456_7000);
    take_rsp("R6 valid entry", 64'h0000_0012_3456_7000, 2'b11);
  endtask

  task automatic t_hit_fault;
    issue(64'h0000_0000_8FFF_FFFF);
    chk("R5 R8 entry addr top page", mem_addr_o, 64'h0000_0001_0047_FFF8);
    mem_rvalid_i = 1'b1; mem_rdata_i = 64'h7FFF_FFFF_FFFF_F000;
    @(negedge clk);
    mem_rvalid_i = 1'b0;
    take_rsp("R7 fault", 64'h0, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_disabled();
    t_window_setup();
    t_miss();
    t_hit_valid();
    t_hit_fault();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule